// File: doc/BRIEF.md
# Frame-Synchronized Register List Loader

This block feeds a continuously running video pipeline with batches of register writes that take effect only on frame boundaries. Software puts a list of register address/data pairs in memory. It then programs the list's byte address, and writes a length word that carries an update-request flag. Once the flag is set, the loader owns the list. Writes to the address and length registers are dropped until the loader accepts the list at the next frame-end pulse and clears the flag.

On acceptance, the address and length are copied into private shadow registers. Software may prepare the next list as soon as the flag reads 0. The loader then reads one 64-bit entry per cycle from memory and replays each entry as a register write on its output port. A frame end with no pending request loads nothing, so the pipeline registers keep their values. Two sticky status flags drive the interrupt outputs and are cleared by writing 1. One flag marks frame ends. The other marks that a list has been fully replayed, after which the loader no longer reads its memory.

Top module: `frame_list_loader`

## Requirements
- R1: After reset the address and length registers, the update flag and both status flags read 0, no register write or memory read is issued, and both interrupt outputs are low.
- R2: Control offset 0 holds the list byte address. Offset 1 holds the length in bytes in bits 10:0 (entries times 8) and the update flag in bit 31. Offset 2 is status, with bit 0 frame-end and bit 1 list-done. Read data appears on the cycle after the offset is presented.
- R3: While the update flag is 1, writes to offsets 0 and 1 have no effect on the stored address, length or flag.
- R4: A frame-end pulse while the flag is 1 and no list is being replayed accepts the list, and the flag reads 0 afterwards.
- R5: An accepted list produces exactly length/8 register writes, in order. Write i carries the upper and lower 32 bits of the memory word at entry index (address/8 + i), modulo the memory depth, as register address and data.
- R6: Rewriting offsets 0 and 1 after acceptance does not alter the list being replayed.
- R7: A frame-end pulse while the flag is 0 issues no writes and sets no list-done flag.
- R8: Every frame-end pulse sets status bit 0. Writing 1 to that bit clears it, but a frame end in the same cycle as the clear leaves it set.
- R9: Status bit 1 is set once the last write of a list has been issued, and it is cleared by writing 1 to it.
- R10: A list of length 0 is accepted, clears the flag, issues no writes and sets status bit 1.
- R11: A frame-end pulse that arrives while a list is still being replayed does not accept a new pending list. The flag stays 1 and the list is taken at the next frame end after the replay ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Control register write strobe |
| cfg_addr | input | 2 | Control register offset |
| cfg_wdata | input | 32 | Control write data |
| cfg_rdata | output | 32 | Control read data, one cycle after cfg_addr |
| frame_end_i | input | 1 | One-cycle frame-end pulse |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | MEM_AW | Memory entry index |
| mem_rd_data | input | 2*DW | Entry returned one cycle after the request |
| rw_valid | output | 1 | Register write strobe |
| rw_addr | output | DW | Register write address |
| rw_data | output | DW | Register write data |
| irq_frame_end | output | 1 | Sticky frame-end status |
| irq_list_done | output | 1 | Sticky list-done status |

## Verification
Two events can land in the same cycle. One is a frame-end pulse, which both sets the frame-end flag and may accept a list. The other is a software access aimed at the same state: a write-1 clear of the frame-end flag, or a rewrite of the length register. The bench drives both in one cycle on purpose. It then expects the flag to stay set, and expects the list already armed, not the colliding rewrite, to be the one replayed. Random lists of varied base and length, including ones that wrap the memory, are compared word by word against a bench model of memory.

// File: rtl/fll_pkg.sv
package fll_pkg;
  localparam int CFG_AW = 2;
  localparam int CFG_DW = 32;

  typedef enum logic [CFG_AW-1:0] {
    OFS_BASE   = 2'd0,
    OFS_LENGTH = 2'd1,
    OFS_STATUS = 2'd2
  } cfg_ofs_e;

  localparam int UPD_BIT     = 31;
  localparam int ST_FE_BIT   = 0;
  localparam int ST_DONE_BIT = 1;
endpackage

// File: rtl/fll_regs.sv
module fll_regs
  import fll_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int SZW    = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr_en,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  output logic [CFG_DW-1:0] cfg_rdata,
  input  logic              frame_end_i,
  input  logic              accept_i,
  input  logic              done_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [SZW-1:0]    size_o,
  output logic              upd_o,
  output logic              fe_flag_o,
  output logic              done_flag_o
);
  logic [ADDR_W-1:0] base_q;
  logic [SZW-1:0]    size_q;
  logic              upd_q, fe_q, done_q;
  logic              wr_base, wr_len, wr_st;

  assign wr_base = cfg_wr_en && cfg_addr == OFS_BASE   && !upd_q;
  assign wr_len  = cfg_wr_en && cfg_addr == OFS_LENGTH && !upd_q;
  assign wr_st   = cfg_wr_en && cfg_addr == OFS_STATUS;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      size_q <= '0;
      upd_q  <= 1'b0;
      fe_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (wr_base) base_q <= cfg_wdata[ADDR_W-1:0];
      if (accept_i) upd_q <= 1'b0;
      else if (wr_len) begin
        size_q <= cfg_wdata[SZW-1:0];
        upd_q  <= cfg_wdata[UPD_BIT];
      end
      fe_q   <= frame_end_i | (fe_q & ~(wr_st & cfg_wdata[ST_FE_BIT]));
      done_q <= done_i | (done_q & ~(wr_st & cfg_wdata[ST_DONE_BIT]));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else begin
      cfg_rdata <= '0;
      case (cfg_addr)
        OFS_BASE:   cfg_rdata[ADDR_W-1:0] <= base_q;
        OFS_LENGTH: begin
          cfg_rdata[SZW-1:0]  <= size_q;
          cfg_rdata[UPD_BIT]  <= upd_q;
        end
        OFS_STATUS: begin
          cfg_rdata[ST_FE_BIT]   <= fe_q;
          cfg_rdata[ST_DONE_BIT] <= done_q;
        end
        default: cfg_rdata <= '0;
      endcase
    end
  end

  assign base_o      = base_q;
  assign size_o      = size_q;
  assign upd_o       = upd_q;
  assign fe_flag_o   = fe_q;
  assign done_flag_o = done_q;

  AST_LOCKED_BASE: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr_en && cfg_addr == OFS_BASE && upd_q) |=> $stable(base_q)); // R3
  AST_LOCKED_SIZE: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr_en && cfg_addr == OFS_LENGTH && upd_q && !accept_i) |=> ($stable(size_q) && upd_q)); // R3
  AST_ACCEPT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    accept_i |=> !upd_q); // R4
  AST_FE_STICKY_SET: assert property (@(posedge clk) disable iff (rst)
    frame_end_i |=> fe_q); // R8
endmodule

// File: rtl/fll_stream.sv
module fll_stream #(
  parameter int ADDR_W = 13,
  parameter int SZW    = 11,
  parameter int MEM_AW = 10,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [SZW-1:0]    size_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              mem_rd_en,
  output logic [MEM_AW-1:0] mem_rd_addr,
  input  logic [2*DW-1:0]   mem_rd_data,
  output logic              rw_valid,
  output logic [DW-1:0]     rw_addr,
  output logic [DW-1:0]     rw_data
);
  localparam int LEN_W = SZW - 3;

  logic [LEN_W-1:0]  entries, rem_q;
  logic [MEM_AW-1:0] first_idx;
  logic              rd_en_q, dv_q, dl_q, busy_q, done_q, rwv_q;
  logic [MEM_AW-1:0] rd_addr_q;
  logic [DW-1:0]     rwa_q, rwd_q;

  assign entries   = size_i[SZW-1:3];
  assign first_idx = base_i[MEM_AW+2:3];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_en_q   <= 1'b0;
      rd_addr_q <= '0;
      rem_q     <= '0;
      dv_q      <= 1'b0;
      dl_q      <= 1'b0;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      rwv_q     <= 1'b0;
      rwa_q     <= '0;
      rwd_q     <= '0;
    end else begin
      if (start_i && entries != '0) begin
        rd_en_q   <= 1'b1;
        rd_addr_q <= first_idx;
        rem_q     <= entries - 1'b1;
      end else if (rd_en_q) begin
        if (rem_q == '0) rd_en_q <= 1'b0;
        else begin
          rem_q     <= rem_q - 1'b1;
          rd_addr_q <= rd_addr_q + 1'b1;
        end
      end
      dv_q  <= rd_en_q;
      dl_q  <= rd_en_q && rem_q == '0;
      rwv_q <= dv_q;
      if (dv_q) begin
        rwa_q <= mem_rd_data[2*DW-1:DW];
        rwd_q <= mem_rd_data[DW-1:0];
      end
      done_q <= (dv_q && dl_q) || (start_i && entries == '0);
      if (start_i && entries != '0) busy_q <= 1'b1;
      else if (dv_q && dl_q)        busy_q <= 1'b0;
    end
  end

  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign mem_rd_en   = rd_en_q;
  assign mem_rd_addr = rd_addr_q;
  assign rw_valid    = rwv_q;
  assign rw_addr     = rwa_q;
  assign rw_data     = rwd_q;

  AST_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    rwv_q |-> (busy_q || done_q)); // R5
  AST_READ_STEP: assert property (@(posedge clk) disable iff (rst)
    (rd_en_q && $past(rd_en_q)) |-> rd_addr_q == $past(rd_addr_q) + 1'b1); // R5
  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (!busy_q && !rd_en_q)); // R9
endmodule

// File: rtl/frame_list_loader.sv
module frame_list_loader
  import fll_pkg::*;
#(
  parameter int MEM_AW = 10,
  parameter int LEN_W  = 8,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr_en,
  input  logic [1:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              frame_end_i,
  output logic              mem_rd_en,
  output logic [MEM_AW-1:0] mem_rd_addr,
  input  logic [2*DW-1:0]   mem_rd_data,
  output logic              rw_valid,
  output logic [DW-1:0]     rw_addr,
  output logic [DW-1:0]     rw_data,
  output logic              irq_frame_end,
  output logic              irq_list_done
);
  localparam int ADDR_W = MEM_AW + 3;
  localparam int SZW    = LEN_W + 3;

  logic [ADDR_W-1:0] base;
  logic [SZW-1:0]    size;
  logic              upd, busy, done, accept;

  assign accept = frame_end_i && upd && !busy;

  fll_regs #(.ADDR_W(ADDR_W), .SZW(SZW)) u_regs (
    .clk(clk), .rst(rst),
    .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata),
    .frame_end_i(frame_end_i), .accept_i(accept), .done_i(done),
    .base_o(base), .size_o(size), .upd_o(upd),
    .fe_flag_o(irq_frame_end), .done_flag_o(irq_list_done)
  );

  fll_stream #(.ADDR_W(ADDR_W), .SZW(SZW), .MEM_AW(MEM_AW), .DW(DW)) u_stream (
    .clk(clk), .rst(rst),
    .start_i(accept), .base_i(base), .size_i(size),
    .busy_o(busy), .done_o(done),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .rw_valid(rw_valid), .rw_addr(rw_addr), .rw_data(rw_data)
  );

  AST_IDLE_FE_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
    (frame_end_i && !upd && !busy) |=> !busy); // R7
  AST_BUSY_BLOCKS_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (frame_end_i && busy && upd) |=> upd); // R11
endmodule

// File: tb/frame_list_loader_tb.sv
module frame_list_loader_tb;
  localparam int MEM_AW = 10;
  localparam int DEPTH  = 1 << MEM_AW;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr_en = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        frame_end_i = 1'b0;
  logic        mem_rd_en;
  logic [MEM_AW-1:0] mem_rd_addr;
  logic [63:0] mem_rd_data = '0;
  logic        rw_valid;
  logic [31:0] rw_addr, rw_data;
  logic        irq_frame_end, irq_list_done;

  int n_chk = 0;
  int n_bad = 0;
  int wr_cnt = 0;
  logic [31:0] got_a [0:511];
  logic [31:0] got_d [0:511];

  always #2.5 clk = ~clk;

  frame_list_loader #(.MEM_AW(MEM_AW)) u_dut (
    .clk(clk), .rst(rst),
    .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .frame_end_i(frame_end_i),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .rw_valid(rw_valid), .rw_addr(rw_addr), .rw_data(rw_data),
    .irq_frame_end(irq_frame_end), .irq_list_done(irq_list_done)
  );

  function automatic logic [63:0] mem_word(input int a);
    logic [31:0] hi, lo;
    hi = 32'h4000_0000 | a;
    lo = a * 32'h9E37_79B9 + 32'h1357;
    return {hi, lo};
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem_word(int'(mem_rd_addr));

  always @(negedge clk) if (rw_valid && wr_cnt < 512) begin
    got_a[wr_cnt] = rw_addr;
    got_d[wr_cnt] = rw_data;
    wr_cnt = wr_cnt + 1;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic cfg_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    @(negedge clk);
    d = cfg_rdata;
  endtask

  task automatic fe_pulse();
    @(negedge clk);
    frame_end_i = 1'b1;
    @(negedge clk);
    frame_end_i = 1'b0;
  endtask

  task automatic wait_done(input int limit);
    for (int i = 0; i < limit && !irq_list_done; i++) @(negedge clk);
  endtask

  task automatic check_list(input int base_e, input int n, input string req);
    logic [63:0] w;
    check(wr_cnt == n, req, wr_cnt, n);
    for (int i = 0; i < n && i < wr_cnt; i++) begin
      w = mem_word((base_e + i) % DEPTH);
      check({got_a[i], got_d[i]} == w, req, {got_a[i], got_d[i]}, w);
    end
  endtask

  task automatic run_list(input int base_e, input int n, input string req);
    logic [31:0] r;
    cfg_wr(2'd2, 32'h3);
    wr_cnt = 0;
    cfg_wr(2'd0, base_e * 8);
    cfg_wr(2'd1, 32'h8000_0000 | (n * 8));
    fe_pulse();
    wait_done(n + 20);
    @(negedge clk);
    check_list(base_e, n, req);
    cfg_rd(2'd1, r);
    check(r[31] == 1'b0, req, r[31], 0);
    check(irq_list_done == 1'b1, req, irq_list_done, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(!rw_valid && !mem_rd_en && !irq_frame_end && !irq_list_done, "R1",
          {rw_valid, mem_rd_en, irq_frame_end, irq_list_done}, 0);
    cfg_rd(2'd0, r); check(r == 0, "R1", r, 0);
    cfg_rd(2'd1, r); check(r == 0, "R1", r, 0);
    cfg_rd(2'd2, r); check(r == 0, "R1", r, 0);

    // R2: register readback
    cfg_wr(2'd0, 32'h0000_0128);
    cfg_rd(2'd0, r); check(r == 32'h128, "R2", r, 32'h128);
    cfg_wr(2'd1, 32'h0000_0040);
    cfg_rd(2'd1, r); check(r == 32'h40, "R2", r, 32'h40);

    // R7: frame end without update request
    wr_cnt = 0;
    fe_pulse();
    repeat (10) @(negedge clk);
    check(wr_cnt == 0, "R7", wr_cnt, 0);
    check(!irq_list_done, "R7", irq_list_done, 0);
    // R8: frame-end flag set, then W1C
    check(irq_frame_end, "R8", irq_frame_end, 1);
    cfg_wr(2'd2, 32'h1);
    check(!irq_frame_end, "R8", irq_frame_end, 0);

    // R4 R5: basic list
    run_list(5, 6, "R5");

    // R9: done flag cleared by write 1
    cfg_wr(2'd2, 32'h2);
    check(!irq_list_done, "R9", irq_list_done, 0);

    // R10: zero-length list
    wr_cnt = 0;
    cfg_wr(2'd1, 32'h8000_0000);
    fe_pulse();
    repeat (8) @(negedge clk);
    check(wr_cnt == 0, "R10", wr_cnt, 0);
    check(irq_list_done, "R10", irq_list_done, 1);
    cfg_rd(2'd1, r); check(r[31] == 0, "R10", r[31], 0);

    // R3: writes locked while update pending
    cfg_wr(2'd2, 32'h3);
    wr_cnt = 0;
    cfg_wr(2'd0, 40 * 8);
    cfg_wr(2'd1, 32'h8000_0000 | (4 * 8));
    cfg_wr(2'd0, 900 * 8);
    cfg_wr(2'd1, 32'h0000_0010);
    cfg_rd(2'd0, r); check(r == 40 * 8, "R3", r, 40 * 8);
    cfg_rd(2'd1, r); check(r == (32'h8000_0000 | 32), "R3", r, 32'h8000_0020);
    // R8 and R3 collision: frame end, W1C of frame flag and length rewrite together
    @(negedge clk);
    frame_end_i = 1'b1; cfg_wr_en = 1'b1; cfg_addr = 2'd1; cfg_wdata = 32'h8000_0050;
    @(negedge clk);
    frame_end_i = 1'b0; cfg_addr = 2'd2; cfg_wdata = 32'h0;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    @(negedge clk);
    frame_end_i = 1'b1; cfg_wr_en = 1'b1; cfg_addr = 2'd2; cfg_wdata = 32'h1;
    @(negedge clk);
    frame_end_i = 1'b0; cfg_wr_en = 1'b0;
    check(irq_frame_end, "R8", irq_frame_end, 1);
    wait_done(30);
    @(negedge clk);
    check_list(40, 4, "R3");

    // R6: rewrite registers during replay
    cfg_wr(2'd2, 32'h3);
    wr_cnt = 0;
    cfg_wr(2'd0, 100 * 8);
    cfg_wr(2'd1, 32'h8000_0000 | (30 * 8));
    fe_pulse();
    cfg_wr(2'd0, 7 * 8);
    cfg_wr(2'd1, 32'h0000_0008);
    wait_done(60);
    @(negedge clk);
    check_list(100, 30, "R6");

    // R11: frame end during replay does not accept
    cfg_wr(2'd2, 32'h3);
    wr_cnt = 0;
    cfg_wr(2'd0, 200 * 8);
    cfg_wr(2'd1, 32'h8000_0000 | (80 * 8));
    fe_pulse();
    cfg_wr(2'd0, 500 * 8);
    cfg_wr(2'd1, 32'h8000_0000 | (3 * 8));
    fe_pulse();
    cfg_rd(2'd1, r); check(r[31] == 1, "R11", r[31], 1);
    wait_done(120);
    @(negedge clk);
    check_list(200, 80, "R11");
    cfg_wr(2'd2, 32'h3);
    wr_cnt = 0;
    fe_pulse();
    wait_done(30);
    @(negedge clk);
    check_list(500, 3, "R11");

    // R5: random lists, some wrapping memory
    for (int k = 0; k < 20; k++) begin
      int b, n;
      b = int'($urandom % DEPTH);
      n = 1 + int'($urandom % 40);
      if (k == 0) begin b = DEPTH - 3; n = 7; end
      run_list(b, n, "R5");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule